// File: doc/BRIEF.md
# Watchdog Timer with Reset Pulse Generator

This block is the digital timing core of a processor supervisor. It counts ticks of a slow timebase, which arrive as a single-cycle enable on the system clock. It also watches a watchdog input for transitions in either direction. If software stops toggling the input for longer than the selected timeout, the block raises a reset pulse on a pair of complementary outputs. It also drops a watchdog status flag, which stays low until the input moves again.

Two mode inputs pick the timing. One of them selects external-clock or internal-timebase operation. The other, in internal mode, selects a long or a short normal timeout. After every reset the long timeout applies, which gives software time to start up. The short period takes over only after the first watchdog transition. A power-fail input holds the reset outputs active and forces the status flag high. The reset pulse is timed only after power-fail is released. An asynchronous active-low power-on reset starts the block inside a reset pulse.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rst_out` is 1, `rst_out_n` is 0 and `wdog_ok` is 1.
- R2: A reset pulse ends on the clock edge that counts its RST_TICKS-th tick while `pwr_fail` is low. `rst_out` and `rst_out_n` are always complementary.
- R3: While `pwr_fail` is 1, from the next edge onward, `rst_out` stays 1 and `wdog_ok` stays 1. The pulse count restarts from zero once `pwr_fail` returns to 0.
- R4: After a reset pulse ends, the timeout is the long post-reset value: EXT_LONG ticks when `ext_clk_mode`=1, and INT_LONG ticks when it is 0. The timeout fires on the edge that counts its last tick.
- R5: With `ext_clk_mode`=1, after the first watchdog transition following a reset, the timeout is EXT_SHORT ticks.
- R6: With `ext_clk_mode`=0 and `long_sel`=1, the timeout is INT_LONG ticks even after watchdog transitions.
- R7: With `ext_clk_mode`=0 and `long_sel`=0, the timeout becomes INT_SHORT ticks after the first watchdog transition following a reset.
- R8: Both rising and falling edges of `wdi` restart the timeout count. Each edge passes through a two-flop synchronizer, so it is acted on at the third rising clock edge after `wdi` changes; the synchronizer resets low. An edge wins over a tick in the same cycle.
- R9: A timeout sets `rst_out` to 1 and `wdog_ok` to 0 on the same edge. `wdog_ok` stays 0, through the reset pulse, until the next acted-on `wdi` edge sets it to 1.
- R10: `ext_clk_mode` and `long_sel` are sampled on every clock while `rst_out` is 1. A change while `rst_out` is 0 has no effect until the next reset pulse.
- R11: Counting advances only on cycles with `tick_en`=1. With `tick_en` held at 0, no timeout occurs and no reset pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_en | input | 1 | Single-cycle timebase tick enable |
| wdi | input | 1 | Watchdog input, asynchronous |
| pwr_fail | input | 1 | Supply-below-threshold indication, active high |
| ext_clk_mode | input | 1 | 1 selects external-clock timing, 0 selects internal timebase |
| long_sel | input | 1 | Internal mode only: 1 keeps the long timeout at all times |
| rst_out | output | 1 | Reset pulse, active high |
| rst_out_n | output | 1 | Reset pulse, active low |
| wdog_ok | output | 1 | Watchdog status, 0 after a timeout |

## Verification
The bench builds the block with RST_TICKS=6, EXT_LONG=30, EXT_SHORT=10, INT_LONG=50 and INT_SHORT=8 instead of the real multi-thousand tick counts. With these values, every timeout kind and the reset pulse finish within a few dozen ticks. The directed part can therefore measure each period exactly in every mode. The random part can then go through hundreds of full timeout, pulse and power-fail cycles, mixed with random watchdog toggles and mode changes.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    typedef enum logic {
        PH_HOLD  = 1'b0,
        PH_WATCH = 1'b1
    } phase_e;

    typedef struct packed {
        logic ext;
        logic long_sel;
    } mode_t;

    function automatic int max_i(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdsup_edge_det.sv
module wdsup_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi,
    output logic edge_o
);
    localparam int W = SYNC_STAGES + 1;

    logic [W-1:0] sh_d;
    logic [W-1:0] sh_q;

    assign sh_d[0] = wdi;
    for (genvar i = 1; i < W; i++) begin : g_stage
        assign sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // oldest two stages differ: one transition, either polarity
    assign edge_o = sh_q[W-1] ^ sh_q[W-2];

endmodule

// File: rtl/wdsup_period_sel.sv
module wdsup_period_sel
    import wdsup_pkg::*;
#(
    parameter int EXT_LONG  = 4096,
    parameter int EXT_SHORT = 1024,
    parameter int INT_LONG  = 16384,
    parameter int INT_SHORT = 1024,
    parameter int CW        = 15
) (
    input  mode_t          mode,
    input  logic           post_rst,
    output logic [CW-1:0]  limit
);
    always_comb begin
        if (post_rst)
            limit = mode.ext ? CW'(EXT_LONG) : CW'(INT_LONG);
        else if (mode.ext)
            limit = CW'(EXT_SHORT);
        else
            limit = mode.long_sel ? CW'(INT_LONG) : CW'(INT_SHORT);
    end
endmodule

// File: rtl/wdsup_core.sv
module wdsup_core
    import wdsup_pkg::*;
#(
    parameter int RST_TICKS = 512,
    parameter int CW        = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wdi_edge,
    input  logic          pwr_fail,
    input  mode_t         mode_in,
    input  logic [CW-1:0] limit,
    output mode_t         mode_q,
    output logic          post_q,
    output logic          rst_active,
    output logic          wdog_ok
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          post;
        logic          ok;
        mode_t         mode;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CW-1:0] cnt_inc;
    logic          timeout;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + CW'(1);
        timeout = 1'b0;
        if (st_q.phase == PH_HOLD) begin
            st_d.mode = mode_in;
            if (pwr_fail) begin
                st_d.cnt = '0;
            end else if (tick_en) begin
                if (cnt_inc == CW'(RST_TICKS)) begin
                    st_d.phase = PH_WATCH;
                    st_d.cnt   = '0;
                    st_d.post  = 1'b1;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end else begin
            if (pwr_fail) begin
                st_d.phase = PH_HOLD;
                st_d.cnt   = '0;
            end else if (wdi_edge) begin
                st_d.cnt  = '0;
                st_d.post = 1'b0;
            end else if (tick_en) begin
                if (cnt_inc == limit) begin
                    timeout    = 1'b1;
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end
        if (pwr_fail || wdi_edge) st_d.ok = 1'b1;
        else if (timeout)         st_d.ok = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_HOLD;
            st_q.cnt   <= '0;
            st_q.post  <= 1'b1;
            st_q.ok    <= 1'b1;
            st_q.mode  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q     = st_q.mode;
    assign post_q     = st_q.post;
    assign rst_active = (st_q.phase == PH_HOLD);
    assign wdog_ok    = st_q.ok;

    // R3: power-fail forces reset and a good status on the next edge
    p_pf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (rst_active && wdog_ok));

    // R9: status only falls together with a reset pulse starting
    p_timeout_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_ok) |-> rst_active);

    // R9: an acted-on edge always leaves the status good
    p_edge_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdi_edge |=> wdog_ok);

    // R4: the count never reaches the active limit while watching
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WATCH) |-> (st_q.cnt < limit));

    // R2: the pulse count stays below its length
    p_pulse_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HOLD) |-> (st_q.cnt < CW'(RST_TICKS)));

    // R11: a pulse can end only on a tick
    p_release_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> $past(tick_en));

    // R10: modes stay frozen while watching
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_active && $past(!rst_active)) |-> $stable(mode_q));

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdsup_pkg::*;
#(
    parameter int RST_TICKS   = 512,
    parameter int EXT_LONG    = 4096,
    parameter int EXT_SHORT   = 1024,
    parameter int INT_LONG    = 16384,
    parameter int INT_SHORT   = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wdi,
    input  logic pwr_fail,
    input  logic ext_clk_mode,
    input  logic long_sel,
    output logic rst_out,
    output logic rst_out_n,
    output logic wdog_ok
);
    localparam int MAX_T = max_i(max_i(max_i(RST_TICKS, EXT_LONG), EXT_SHORT),
                                 max_i(INT_LONG, INT_SHORT));
    localparam int CW    = $clog2(MAX_T + 1);

    logic          wdi_edge;
    logic [CW-1:0] limit;
    mode_t         mode_in;
    mode_t         mode_q;
    logic          post_q;
    logic          rst_active;

    assign mode_in.ext      = ext_clk_mode;
    assign mode_in.long_sel = long_sel;

    wdsup_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdi    (wdi),
        .edge_o (wdi_edge)
    );

    wdsup_period_sel #(
        .EXT_LONG (EXT_LONG),
        .EXT_SHORT(EXT_SHORT),
        .INT_LONG (INT_LONG),
        .INT_SHORT(INT_SHORT),
        .CW       (CW)
    ) i_sel (
        .mode    (mode_q),
        .post_rst(post_q),
        .limit   (limit)
    );

    wdsup_core #(.RST_TICKS(RST_TICKS), .CW(CW)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wdi_edge  (wdi_edge),
        .pwr_fail  (pwr_fail),
        .mode_in   (mode_in),
        .limit     (limit),
        .mode_q    (mode_q),
        .post_q    (post_q),
        .rst_active(rst_active),
        .wdog_ok   (wdog_ok)
    );

    assign rst_out   = rst_active;
    assign rst_out_n = ~rst_active;

endmodule

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;
    localparam int RST = 6;
    localparam int EL  = 30;
    localparam int ES  = 10;
    localparam int IL  = 50;
    localparam int IS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1, wdi = 1'b0, pwr_fail = 1'b0;
    logic ext_clk_mode = 1'b1, long_sel = 1'b0;
    logic rst_out, rst_out_n, wdog_ok;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_supervisor #(.RST_TICKS(RST), .EXT_LONG(EL), .EXT_SHORT(ES),
                      .INT_LONG(IL), .INT_SHORT(IS)) i_wdog_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdi(wdi),
        .pwr_fail(pwr_fail), .ext_clk_mode(ext_clk_mode), .long_sel(long_sel),
        .rst_out(rst_out), .rst_out_n(rst_out_n), .wdog_ok(wdog_ok)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // timeout from the requirements (R4-R7)
    function automatic int exp_timeout(bit ext, bit lsel, bit post);
        if (post) return ext ? EL : IL;
        if (ext)  return ES;
        return lsel ? IL : IS;
    endfunction

    // reference model, updated from the requirement text
    bit       m_hold, m_post, m_ok, m_ext, m_lsel;
    int       m_cnt;
    bit [2:0] m_sh;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold <= 1; m_post <= 1; m_ok <= 1; m_cnt <= 0;
            m_ext <= 0; m_lsel <= 0; m_sh <= '0;
        end else begin
            bit e;
            e = m_sh[1] ^ m_sh[2];
            m_sh <= {m_sh[1:0], wdi};
            if (m_hold) begin
                m_ext <= ext_clk_mode; m_lsel <= long_sel;
                if (pwr_fail) m_cnt <= 0;
                else if (tick_en) begin
                    if (m_cnt + 1 == RST) begin
                        m_hold <= 0; m_cnt <= 0; m_post <= 1;
                    end else m_cnt <= m_cnt + 1;
                end
                if (pwr_fail || e) m_ok <= 1;
            end else begin
                if (pwr_fail) begin
                    m_hold <= 1; m_cnt <= 0; m_ok <= 1;
                end else if (e) begin
                    m_cnt <= 0; m_post <= 0; m_ok <= 1;
                end else if (tick_en) begin
                    if (m_cnt + 1 == exp_timeout(m_ext, m_lsel, m_post)) begin
                        m_hold <= 1; m_cnt <= 0; m_ok <= 0;
                    end else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model rst_out", rst_out, m_hold);
            chk("R2 rst_out_n complement", rst_out_n, !m_hold);
            chk("R9 model wdog_ok", wdog_ok, m_ok);
        end
    end

    task automatic count_until(bit want, output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (rst_out != want && n < 1000);
    endtask

    task automatic toggle_settle();
        tick_en = 1'b0;
        wdi = ~wdi;
        repeat (4) @(negedge clk);
        tick_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int pf_left;
        void'($urandom(32'h5eed1));
        repeat (3) @(negedge clk);
        chk("R1 rst_out in reset", rst_out, 1);
        chk("R1 rst_out_n in reset", rst_out_n, 0);
        chk("R1 wdog_ok in reset", wdog_ok, 1);
        rst_n = 1'b1;
        chk("R1 rst_out after release", rst_out, 1);
        chk("R1 wdog_ok after release", wdog_ok, 1);

        count_until(0, n); chk("R2 pulse length", n, RST);
        count_until(1, n); chk("R4 ext post-reset timeout", n, exp_timeout(1, 0, 1));
        chk("R9 status low at timeout", wdog_ok, 0);
        count_until(0, n); chk("R2 pulse after timeout", n, RST);
        chk("R9 status held low through pulse", wdog_ok, 0);

        toggle_settle();
        chk("R9 status set by wdi edge", wdog_ok, 1);
        count_until(1, n); chk("R5 ext short timeout", n, exp_timeout(1, 0, 0));
        ext_clk_mode = 1'b0; long_sel = 1'b0;
        count_until(0, n); chk("R2 pulse length", n, RST);
        count_until(1, n); chk("R4 int post-reset timeout", n, exp_timeout(0, 0, 1));
        count_until(0, n);
        toggle_settle();
        count_until(1, n); chk("R7 int short timeout", n, exp_timeout(0, 0, 0));
        count_until(0, n);
        long_sel = 1'b1;
        toggle_settle();
        count_until(1, n); chk("R10 mode change while watching ignored", n, IS);
        count_until(0, n);
        toggle_settle();
        count_until(1, n); chk("R6 int long after transition", n, exp_timeout(0, 1, 0));
        long_sel = 1'b0;
        count_until(0, n);

        // R8: alternate rising/falling edges keep restarting the count
        toggle_settle();
        for (int i = 0; i < 6; i++) begin
            repeat (IS - 3) @(negedge clk);
            toggle_settle();
            chk("R8 edges restart timeout", rst_out, 0);
        end

        // R11: no ticks, no timeout
        tick_en = 1'b0;
        repeat (200) @(negedge clk);
        chk("R11 no count without tick", rst_out, 0);
        chk("R11 status unchanged without tick", wdog_ok, 1);
        tick_en = 1'b1;

        // R3: power-fail after a timeout
        count_until(1, n); chk("R4 timeout before power-fail", n, IS);
        chk("R9 status low before power-fail", wdog_ok, 0);
        pwr_fail = 1'b1;
        @(negedge clk);
        chk("R3 status forced high", wdog_ok, 1);
        repeat (20) @(negedge clk);
        chk("R3 reset held during power-fail", rst_out, 1);
        pwr_fail = 1'b0;
        count_until(0, n); chk("R3 pulse timed after release", n, RST);
        pwr_fail = 1'b1;
        @(negedge clk);
        chk("R3 power-fail while watching", rst_out, 1);
        pwr_fail = 1'b0;

        // random phase, checked against the model each cycle
        pf_left = 0;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            tick_en = ($urandom % 3) != 0;
            if ($urandom % 14 == 0) wdi = ~wdi;
            if (pf_left > 0) pf_left--;
            else if ($urandom % 250 == 0) pf_left = 1 + $urandom % 15;
            pwr_fail = (pf_left > 0);
            if ($urandom % 60 == 0) ext_clk_mode = ~ext_clk_mode;
            if ($urandom % 60 == 0) long_sel = ~long_sel;
        end
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule